// File: doc/BRIEF.md
# Shared Counter with Per-Processor Compare Interrupts

This block keeps one free-running counter that all virtual processors share, plus a 64-bit compare register for each processor. When the counter reaches or passes a processor's compare value, that processor's compare interrupt is raised on its own pending output. The interrupt stays raised until software writes that processor's compare register again.

Software reaches the block through a simple register port. The port has two spaces. The shared space holds a configuration word and the counter. The local space holds one processor's pending view and compare register, and a processor-select input picks which one. The counter and the compare registers can be written as one 64-bit word. They can also be written as two 32-bit halves: the low half is held aside, and the high-half write applies both halves in one cycle. A control bit in the configuration word freezes the counter. The same word also reports, read-only, the implemented counter width, the number of shared interrupt sources and the number of processors.

Top module: `shared_timer_cmp`

## Requirements
- R1: After reset the counter is 0, every compare register is all ones, every pending output is 0 and the freeze bit is 0.
- R2: While not frozen and not being written, the counter rises by exactly 1 each clock and wraps at 2^CNT_W.
- R3: Shared offset 0x000 reads bit 28 = freeze, bits 27:24 = (CNT_W-32)/4, bits 23:16 = NUM_SHARED/8-1, bits 6:0 = NUM_VP-1, and all other bits 0. A write changes only bit 28.
- R4: With the freeze bit set the counter holds its value. Clearing the bit resumes counting from the held value. A counter write still loads while frozen.
- R5: A wide write (reg_wide=1) to shared offset 0x010 loads the whole counter on that clock edge. A wide read of 0x010 returns the full counter.
- R6: A 32-bit write to shared 0x010 is held aside and leaves the counter running untouched. A 32-bit write to 0x014 loads {wdata[31:0], held low half}. A 32-bit read of 0x010 returns the low half and a 32-bit read of 0x014 returns the high half, both in bits 31:0.
- R7: Each processor's compare register sits at local offset 0x0a0 (wide write or read). It can also be written as a held 32-bit low half at 0x0a0 followed by a committing high half at 0x0a4. A write affects only the processor selected by reg_vp.
- R8: cmp_pend[v] becomes 1 on the clock edge that samples counter >= compare[v], and then stays 1 until compare[v] is written.
- R9: A commit to compare[v] clears cmp_pend[v] on that edge. The condition is evaluated again from the next edge on.
- R10: Local offset 0x004 reads the selected processor's compare interrupt at bit 1 (bit 0 is reserved for a watchdog and reads 0). All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for this cycle |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_local | input | 1 | 0 = shared space, 1 = local space of the processor selected by reg_vp |
| reg_vp | input | VPW | Processor select for local accesses |
| reg_addr | input | AW | Byte offset in the selected space |
| reg_wdata | input | 64 | Write data (bits 31:0 used for 32-bit writes) |
| reg_rdata | output | 64 | Read data for the current address, combinational |
| cmp_pend | output | NUM_VP | Compare interrupt pending, one bit per processor |

## Verification
The hardest case to reach is the window between the two halves of a split counter write. The stimulus has to build a counter and a compare value so that the old high half combined with the new low half would pass the compare, while both the old and the new full values stay below it. The bench loads the counter to 0x1_0000_0000 and a compare of 0x1_8000_0000. It then writes a low half of 0xF000_0000, idles, and writes a high half of 0, so any premature merge shows up at once as a false interrupt. A separate case freezes the counter, writes it, and then resumes, to check that the held value and the loaded value both take effect.

// File: rtl/shared_timer_cmp.sv
module shared_timer_cmp #(
  parameter int NUM_VP     = 4,
  parameter int CNT_W      = 64,
  parameter int NUM_SHARED = 64,
  parameter int AW         = 8,
  localparam int VPW       = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_wide,
  input  logic              reg_local,
  input  logic [VPW-1:0]    reg_vp,
  input  logic [AW-1:0]     reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic [NUM_VP-1:0] cmp_pend
);
  localparam logic [AW-1:0] A_CFG    = AW'('h000);
  localparam logic [AW-1:0] A_CNT_LO = AW'('h010);
  localparam logic [AW-1:0] A_CNT_HI = AW'('h014);
  localparam logic [AW-1:0] A_PEND   = AW'('h004);
  localparam logic [AW-1:0] A_CMP_LO = AW'('h0a0);
  localparam logic [AW-1:0] A_CMP_HI = AW'('h0a4);
  localparam logic [3:0]    WCODE    = 4'((CNT_W - 32) / 4);
  localparam logic [7:0]    SCODE    = 8'(NUM_SHARED / 8 - 1);
  localparam logic [6:0]    VCODE    = 7'(NUM_VP - 1);

  logic [CNT_W-1:0]           cnt_q;
  logic [31:0]                cnt_stage;
  logic                       stop_q;
  logic [NUM_VP-1:0][63:0]    cmp_q;
  logic [NUM_VP-1:0][31:0]    cmp_stage;
  logic [NUM_VP-1:0]          cmp_wr;

  wire        sh_wr      = reg_we & ~reg_local;
  wire        lc_wr      = reg_we &  reg_local;
  wire        vp_ok      = 32'(reg_vp) < NUM_VP;
  wire        cfg_wr     = sh_wr & (reg_addr == A_CFG);
  wire        cnt_lo_wr  = sh_wr & ~reg_wide & (reg_addr == A_CNT_LO);
  wire        cnt_commit = sh_wr & (( reg_wide & (reg_addr == A_CNT_LO)) |
                                    (~reg_wide & (reg_addr == A_CNT_HI)));
  wire [63:0] cnt_new    = reg_wide ? reg_wdata : {reg_wdata[31:0], cnt_stage};
  wire [63:0] cnt64      = 64'(cnt_q);
  wire [31:0] cfg_word   = {3'b000, stop_q, WCODE, SCODE, 9'd0, VCODE};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      cnt_stage <= '0;
      stop_q    <= 1'b0;
    end else begin
      if (cfg_wr)         stop_q    <= reg_wdata[28];
      if (cnt_lo_wr)      cnt_stage <= reg_wdata[31:0];
      if (cnt_commit)     cnt_q     <= cnt_new[CNT_W-1:0];
      else if (!stop_q)   cnt_q     <= cnt_q + 1'b1;
    end
  end

  for (genvar v = 0; v < NUM_VP; v++) begin : g_vp
    wire sel      = lc_wr & vp_ok & (reg_vp == VPW'(v));
    wire stage_wr = sel & ~reg_wide & (reg_addr == A_CMP_LO);
    assign cmp_wr[v] = sel & (( reg_wide & (reg_addr == A_CMP_LO)) |
                              (~reg_wide & (reg_addr == A_CMP_HI)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_q[v]     <= '1;
        cmp_stage[v] <= '0;
        cmp_pend[v]  <= 1'b0;
      end else begin
        if (stage_wr) cmp_stage[v] <= reg_wdata[31:0];
        if (cmp_wr[v]) begin
          cmp_q[v]    <= reg_wide ? reg_wdata : {reg_wdata[31:0], cmp_stage[v]};
          cmp_pend[v] <= 1'b0;
        end else if (cnt64 >= cmp_q[v]) begin
          cmp_pend[v] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (!reg_local) begin
      case (reg_addr)
        A_CFG:    reg_rdata[31:0] = cfg_word;
        A_CNT_LO: reg_rdata       = reg_wide ? cnt64 : {32'd0, cnt64[31:0]};
        A_CNT_HI: reg_rdata[31:0] = cnt64[63:32];
        default:  reg_rdata       = '0;
      endcase
    end else if (vp_ok) begin
      case (reg_addr)
        A_PEND:   reg_rdata[1]    = cmp_pend[reg_vp];
        A_CMP_LO: reg_rdata       = reg_wide ? cmp_q[reg_vp] : {32'd0, cmp_q[reg_vp][31:0]};
        A_CMP_HI: reg_rdata[31:0] = cmp_q[reg_vp][63:32];
        default:  reg_rdata       = '0;
      endcase
    end
  end
endmodule

// File: rtl/shared_timer_cmp_chk.sv
module shared_timer_cmp_chk #(
  parameter int NUM_VP = 4,
  parameter int CNT_W  = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    stop_q,
  input logic                    cnt_commit,
  input logic [CNT_W-1:0]        cnt_q,
  input logic [NUM_VP-1:0][63:0] cmp_q,
  input logic [NUM_VP-1:0]       cmp_wr,
  input logic [NUM_VP-1:0]       pend
);
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_q && !cnt_commit) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  p_frozen_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !cnt_commit) |=> $stable(cnt_q));

  for (genvar v = 0; v < NUM_VP; v++) begin : g_a
    p_pend_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[v] && !cmp_wr[v]) |=> pend[v]);

    p_pend_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[v]) |-> $past(64'(cnt_q) >= cmp_q[v]));

    p_pend_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_wr[v] |=> !pend[v]);
  end
endmodule

bind shared_timer_cmp shared_timer_cmp_chk #(.NUM_VP(NUM_VP), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_q(stop_q), .cnt_commit(cnt_commit),
  .cnt_q(cnt_q), .cmp_q(cmp_q), .cmp_wr(cmp_wr), .pend(cmp_pend)
);

// File: tb/shared_timer_cmp_tb.sv
module shared_timer_cmp_tb;
  localparam int CLK_P = 10;
  localparam int NV    = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0, reg_wide = 0, reg_local = 0;
  logic [1:0]  reg_vp = 0;
  logic [7:0]  reg_addr = 0;
  logic [63:0] reg_wdata = 0;
  logic [63:0] reg_rdata;
  logic [NV-1:0] cmp_pend;

  int n_chk = 0, n_fail = 0;

  logic [63:0] m_cnt, m_cstage;
  logic        m_stop;
  logic [63:0] m_cmp [NV];
  logic [31:0] m_pstage [NV];
  logic [NV-1:0] m_pend;

  shared_timer_cmp #(.NUM_VP(NV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wide(reg_wide),
    .reg_local(reg_local), .reg_vp(reg_vp), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_pend(cmp_pend)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cstage = 0; m_stop = 0; m_pend = 0;
      for (int v = 0; v < NV; v++) begin m_cmp[v] = '1; m_pstage[v] = 0; end
    end else begin
      logic commit;
      for (int v = 0; v < NV; v++) begin
        logic cw;
        cw = reg_we && reg_local && reg_vp == v &&
             ((reg_wide && reg_addr == 8'ha0) || (!reg_wide && reg_addr == 8'ha4));
        if (cw) m_pend[v] = 0;
        else if (m_cnt >= m_cmp[v]) m_pend[v] = 1;
        if (cw) m_cmp[v] = reg_wide ? reg_wdata : {reg_wdata[31:0], m_pstage[v]};
        if (reg_we && reg_local && reg_vp == v && !reg_wide && reg_addr == 8'ha0)
          m_pstage[v] = reg_wdata[31:0];
      end
      commit = reg_we && !reg_local &&
               ((reg_wide && reg_addr == 8'h10) || (!reg_wide && reg_addr == 8'h14));
      if (commit) m_cnt = reg_wide ? reg_wdata : {reg_wdata[31:0], m_cstage[31:0]};
      else if (!m_stop) m_cnt = m_cnt + 1;
      if (reg_we && !reg_local && !reg_wide && reg_addr == 8'h10) m_cstage = {32'd0, reg_wdata[31:0]};
      if (reg_we && !reg_local && reg_addr == 8'h00) m_stop = reg_wdata[28];
    end
  end

  // R8 R9: pending outputs compared with the model on every clock
  always @(negedge clk) if (rst_n) check("R8/R9 pend", 64'(cmp_pend), 64'(m_pend));

  function automatic logic [63:0] model_rd(input logic loc, input int vp, input logic [7:0] a, input logic wide);
    if (!loc) begin
      case (a)
        8'h00: return {32'd0, 3'b000, m_stop, 4'd8, 8'd7, 9'd0, 7'(NV-1)};
        8'h10: return wide ? m_cnt : {32'd0, m_cnt[31:0]};
        8'h14: return {32'd0, m_cnt[63:32]};
        default: return 0;
      endcase
    end
    case (a)
      8'h04: return {62'd0, m_pend[vp], 1'b0};
      8'ha0: return wide ? m_cmp[vp] : {32'd0, m_cmp[vp][31:0]};
      8'ha4: return {32'd0, m_cmp[vp][63:32]};
      default: return 0;
    endcase
  endfunction

  task automatic wr(input logic loc, input int vp, input logic [7:0] a, input logic wide, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1; reg_local = loc; reg_vp = 2'(vp); reg_addr = a; reg_wide = wide; reg_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); reg_we = 0; end
  endtask

  task automatic rd(input string req, input logic loc, input int vp, input logic [7:0] a, input logic wide);
    @(negedge clk);
    reg_we = 0; reg_local = loc; reg_vp = 2'(vp); reg_addr = a; reg_wide = wide;
    #1 check(req, reg_rdata, model_rd(loc, vp, a, wide));
  endtask

  logic [63:0] snap;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd("R1 compare reset", 1, 0, 8'ha0, 1);
    rd("R1 compare reset vp3", 1, 3, 8'ha0, 1);
    rd("R1 counter after reset", 0, 0, 8'h10, 1);
    check("R1 pend reset", 64'(cmp_pend), 64'd0);
    // R3 configuration word
    rd("R3 config", 0, 0, 8'h00, 0);
    check("R3 config value", reg_rdata, 64'h0807_0003);
    wr(0, 0, 8'h00, 0, 64'hFFFF_FFFF);
    rd("R3 config after write", 0, 0, 8'h00, 0);
    check("R3 only freeze bit", reg_rdata, 64'h1807_0003);
    // R4 frozen counter holds
    rd("R4 frozen read a", 0, 0, 8'h10, 1);
    snap = reg_rdata;
    idle(5);
    rd("R4 frozen read b", 0, 0, 8'h10, 1);
    check("R4 held value", reg_rdata, snap);
    wr(0, 0, 8'h10, 1, 64'h0000_0000_0000_1000);
    idle(3);
    rd("R4 load while frozen", 0, 0, 8'h10, 1);
    check("R4 loaded held", reg_rdata, 64'h1000);
    wr(0, 0, 8'h00, 0, 64'h0);
    idle(4);
    rd("R4 resume", 0, 0, 8'h10, 1);
    // R2 wrap of the counter
    wr(0, 0, 8'h10, 1, 64'hFFFF_FFFF_FFFF_FFFE);
    idle(3);
    rd("R2 wrap", 0, 0, 8'h10, 1);
    // R5 wide load and R6 half reads
    wr(0, 0, 8'h10, 1, 64'h1234_5678_0000_0100);
    rd("R6 low half", 0, 0, 8'h10, 0);
    rd("R6 high half", 0, 0, 8'h14, 0);
    rd("R5 wide read", 0, 0, 8'h10, 1);
    // R8 compare match on vp2, R10 local view
    wr(1, 2, 8'ha0, 1, m_cnt + 64'd12);
    idle(8);
    rd("R10 pend before", 1, 2, 8'h04, 0);
    check("R10 bit1 clear", reg_rdata, 64'd0);
    idle(8);
    rd("R10 pend after", 1, 2, 8'h04, 0);
    check("R8 vp2 raised", reg_rdata, 64'd2);
    rd("R10 other vp", 1, 1, 8'h04, 0);
    // R8 sticky after counter moved back below
    wr(0, 0, 8'h10, 1, 64'h0);
    idle(3);
    check("R8 sticky", 64'(cmp_pend[2]), 64'd1);
    // R9 clear by compare rewrite above counter, R7 split compare write
    wr(1, 2, 8'ha0, 0, 64'h0000_0500);
    idle(2);
    check("R7 low staged only", 64'(cmp_pend[2]), 64'd1);
    wr(1, 2, 8'ha4, 0, 64'h0);
    idle(1);
    check("R9 cleared", 64'(cmp_pend[2]), 64'd0);
    rd("R7 split compare", 1, 2, 8'ha0, 1);
    check("R7 compare value", reg_rdata, 64'h500);
    rd("R7 other vp untouched", 1, 1, 8'ha0, 1);
    // R6 split counter write without a false match
    wr(0, 0, 8'h10, 1, 64'h1_0000_0000);
    wr(1, 1, 8'ha0, 1, 64'h1_8000_0000);
    wr(0, 0, 8'h10, 0, 64'hF000_0000);
    idle(5);
    check("R6 no false match", 64'(cmp_pend[1]), 64'd0);
    rd("R6 counter untouched by low", 0, 0, 8'h10, 1);
    wr(0, 0, 8'h14, 0, 64'h0);
    idle(5);
    check("R6 no match after commit", 64'(cmp_pend[1]), 64'd0);
    rd("R6 committed value", 0, 0, 8'h10, 1);
    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule